// File: doc/BRIEF.md
# Instruction Window Address Translator

This block turns a logical instruction byte offset into a physical byte address. The logical space is cut into a fixed number of equal windows, 128 KB each by default, with two windows. Each window has its own 16-bit map word, and that word chooses where the window lands. A window can land in unified memory, chosen by a 7-bit segment number. It can land in the on-chip instruction memory at the window's own fixed place. It can fold into a small 2 KB test area at the bottom of instruction memory. One encoding is reserved and is reported as an error.

A caller gives an offset and a byte count. The block answers in the same cycle, with no clock in the path. It returns the physical address, the byte count cut so that the access stays inside one window (or inside the 2 KB test area), and an error flag. The map words sit behind a clocked write port and a combinational read port. A parameter picks their reset values: either the hard-reset profile or the alternative boot profile, in which both windows start in on-chip instruction memory.

Top module: `iwin_xlate`

## Requirements
- R1: After reset with the default profile, window 0 holds 0x0000 and window 1 holds 0x007F. With the alternative boot profile (BOOT_PROFILE=1), both windows hold 0x1000.
- R2: A write with `map_we` high updates the selected map word at the next rising clock edge. `map_rdata` shows the word picked by `map_rsel`. A translation in the same cycle as a write still uses the old map word. Without a write, the word does not change.
- R3: Any offset of 0x40000 or more (window count × window size) gives `xl_err`=1, `xl_len`=0 and `xl_phys`=0.
- R4: The window index is offset bit 17 (offset / 0x20000). The offset inside the window is bits 16:0.
- R5: Map bits 13:12 give the target: 0 is unified, 1 is instruction memory, 2 is reserved, 3 is test. Bits 6:0 give the segment number. All other map bits have no effect.
- R6: Target 0 gives `xl_phys` = 0x00000000 + (segment << 17) + in-window offset.
- R7: Target 1 gives `xl_phys` = 0x01000000 + 0x20000 × window index + in-window offset.
- R8: Target 2 gives `xl_err`=1 with `xl_len`=0 and `xl_phys`=0.
- R9: Target 3 gives `xl_phys` = 0x01000000 + (in-window offset mod 0x800). The length is cut so that the access ends at or before the next 0x800 boundary.
- R10: For targets 0 and 1, `xl_len` = min(`req_len`, 0x20000 − in-window offset).
- R11: A request length of zero gives length zero and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the map register write port |
| rst_n | input | 1 | Asynchronous active-low reset of the map words |
| map_we | input | 1 | Write strobe for a map word |
| map_wsel | input | 1 | Index of the map word to write |
| map_wdata | input | 16 | Value to write |
| map_rsel | input | 1 | Index of the map word to read |
| map_rdata | output | 16 | Current value of the map word picked by `map_rsel` |
| req_off | input | 24 | Logical instruction byte offset |
| req_len | input | 16 | Requested byte count |
| xl_phys | output | 32 | Translated physical byte address |
| xl_len | output | 16 | Byte count after boundary clipping |
| xl_err | output | 1 | Offset out of range or reserved target |

## Verification
A map-word write and a translation that reads the same word can fall in the same cycle. The bench provokes this on purpose: it writes a window's map word while it requests an offset in that window. It then checks that the result follows the old target in that cycle and the new target in the cycle after. A behavioural model keeps its own copy of the map words. It updates that copy only after the clock edge, and it compares every output on every cycle. Both directed and random mixes of writes and requests are run.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

   // Target classes decoded from the two target bits of a map word
   typedef enum logic [1:0] {
      TGT_UNIFIED = 2'd0,
      TGT_INSN    = 2'd1,
      TGT_RSVD    = 2'd2,
      TGT_TEST    = 2'd3
   } iwin_tgt_e;

   // Reset value of map word idx under a given boot profile
   function automatic logic [31:0] boot_word(input int profile, input int idx);
      logic [31:0] v;
      if (profile == 1) begin
         v = 32'h0000_1000;
      end else begin
         v = (idx == 0) ? 32'h0000_0000 : 32'h0000_007F;
      end
      return v;
   endfunction

endpackage

// File: rtl/iwin_map_regs.sv
module iwin_map_regs #(
   parameter int MAP_W        = 16,
   parameter int NUM_WIN      = 2,
   parameter int SEL_W        = 1,
   parameter int BOOT_PROFILE = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [SEL_W-1:0]                wsel,
   input  logic [MAP_W-1:0]                wdata,
   input  logic [SEL_W-1:0]                rsel,
   output logic [MAP_W-1:0]                rdata,
   output logic [NUM_WIN-1:0][MAP_W-1:0]   maps
);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [MAP_W-1:0] RST_VAL =
         MAP_W'(iwin_pkg::boot_word(BOOT_PROFILE, w));
      logic [MAP_W-1:0] word_q;
      logic             hit;

      assign hit = we && (wsel == SEL_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= RST_VAL;
         end else if (hit) begin
            word_q <= wdata;
         end
      end

      assign maps[w] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (rsel == SEL_W'(w)) begin
            rdata = maps[w];
         end
      end
   end

endmodule

// File: rtl/iwin_route.sv
module iwin_route #(
   parameter int          MAP_W     = 16,
   parameter int          PA_W      = 32,
   parameter int          WIN_LG    = 17,
   parameter int          SEL_W     = 1,
   parameter int          SEG_W     = 7,
   parameter int          TGT_LSB   = 12,
   parameter int          TEST_LG   = 11,
   parameter logic [31:0] UNI_BASE  = 32'h0000_0000,
   parameter logic [31:0] INSN_BASE = 32'h0100_0000
) (
   input  logic [MAP_W-1:0]    map_word,
   input  logic [SEL_W-1:0]    win_sel,
   input  logic [WIN_LG-1:0]   win_off,
   output iwin_pkg::iwin_tgt_e tgt,
   output logic [PA_W-1:0]     phys
);
   import iwin_pkg::*;

   logic [SEG_W-1:0]   seg;
   logic [TEST_LG-1:0] test_off;
   logic [PA_W-1:0]    pa_uni;
   logic [PA_W-1:0]    pa_insn;
   logic [PA_W-1:0]    pa_test;

   assign tgt      = iwin_tgt_e'(map_word[TGT_LSB +: 2]);
   assign seg      = map_word[SEG_W-1:0];
   assign test_off = win_off[TEST_LG-1:0];

   assign pa_uni  = PA_W'(UNI_BASE)  + (PA_W'(seg) << WIN_LG)     + PA_W'(win_off);
   assign pa_insn = PA_W'(INSN_BASE) + (PA_W'(win_sel) << WIN_LG) + PA_W'(win_off);
   assign pa_test = PA_W'(INSN_BASE) + PA_W'(test_off);

   always_comb begin
      unique case (tgt)
         TGT_UNIFIED: phys = pa_uni;
         TGT_INSN:    phys = pa_insn;
         TGT_TEST:    phys = pa_test;
         default:     phys = '0;
      endcase
   end

endmodule

// File: rtl/iwin_clip.sv
module iwin_clip #(
   parameter int LEN_W   = 16,
   parameter int WIN_LG  = 17,
   parameter int TEST_LG = 11
) (
   input  logic [LEN_W-1:0]  req_len,
   input  logic [WIN_LG-1:0] win_off,
   input  logic              test_mode,
   output logic [LEN_W-1:0]  len_out
);
   localparam int CW = (LEN_W > WIN_LG + 1) ? LEN_W : WIN_LG + 1;

   logic [CW-1:0] room_win;
   logic [CW-1:0] room_tst;
   logic [CW-1:0] room;
   logic [CW-1:0] want;

   assign room_win = (CW'(1) << WIN_LG)  - CW'(win_off);
   assign room_tst = (CW'(1) << TEST_LG) - CW'(win_off[TEST_LG-1:0]);
   assign room     = test_mode ? room_tst : room_win;
   assign want     = CW'(req_len);
   assign len_out  = (want > room) ? LEN_W'(room) : req_len;

endmodule

// File: rtl/iwin_xlate.sv
module iwin_xlate #(
   parameter int          MAP_W        = 16,
   parameter int          NUM_WIN      = 2,
   parameter int          WIN_LG       = 17,
   parameter int          OFF_W        = 24,
   parameter int          LEN_W        = 16,
   parameter int          PA_W         = 32,
   parameter int          SEG_W        = 7,
   parameter int          TGT_LSB      = 12,
   parameter int          TEST_LG      = 11,
   parameter logic [31:0] UNI_BASE     = 32'h0000_0000,
   parameter logic [31:0] INSN_BASE    = 32'h0100_0000,
   parameter int          BOOT_PROFILE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             map_we,
   input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] map_wsel,
   input  logic [MAP_W-1:0] map_wdata,
   input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] map_rsel,
   output logic [MAP_W-1:0] map_rdata,
   input  logic [OFF_W-1:0] req_off,
   input  logic [LEN_W-1:0] req_len,
   output logic [PA_W-1:0]  xl_phys,
   output logic [LEN_W-1:0] xl_len,
   output logic             xl_err
);
   import iwin_pkg::*;

   localparam int     SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam longint SPAN  = longint'(NUM_WIN) << WIN_LG;

   // elaboration-time parameter checks
   if (OFF_W < WIN_LG + SEL_W) begin : g_chk_off
      $error("OFF_W too narrow for window count and size");
   end
   if (TEST_LG > WIN_LG) begin : g_chk_test
      $error("test area larger than a window");
   end
   if (TGT_LSB + 2 > MAP_W || SEG_W > TGT_LSB) begin : g_chk_map
      $error("map word field layout does not fit");
   end
   if (BOOT_PROFILE != 0 && BOOT_PROFILE != 1) begin : g_chk_boot
      $error("BOOT_PROFILE must be 0 or 1");
   end
   if (NUM_WIN < 1) begin : g_chk_win
      $error("NUM_WIN must be at least 1");
   end

   logic [NUM_WIN-1:0][MAP_W-1:0] maps;
   logic [SEL_W-1:0]              win_sel;
   logic [WIN_LG-1:0]             win_off;
   logic                          in_range;
   logic [MAP_W-1:0]              map_word;
   iwin_tgt_e                     tgt;
   logic [PA_W-1:0]               route_pa;
   logic [LEN_W-1:0]              clip_len;
   logic                          bad;

   iwin_map_regs #(
      .MAP_W(MAP_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .BOOT_PROFILE(BOOT_PROFILE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(map_we), .wsel(map_wsel), .wdata(map_wdata),
      .rsel(map_rsel), .rdata(map_rdata), .maps(maps)
   );

   assign in_range = ({1'b0, req_off} < (OFF_W + 1)'(SPAN));
   assign win_off  = req_off[WIN_LG-1:0];
   assign win_sel  = req_off[WIN_LG +: SEL_W];

   always_comb begin
      map_word = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (win_sel == SEL_W'(w)) begin
            map_word = maps[w];
         end
      end
   end

   iwin_route #(
      .MAP_W(MAP_W), .PA_W(PA_W), .WIN_LG(WIN_LG), .SEL_W(SEL_W), .SEG_W(SEG_W),
      .TGT_LSB(TGT_LSB), .TEST_LG(TEST_LG), .UNI_BASE(UNI_BASE), .INSN_BASE(INSN_BASE)
   ) u_route (
      .map_word(map_word), .win_sel(win_sel), .win_off(win_off),
      .tgt(tgt), .phys(route_pa)
   );

   iwin_clip #(
      .LEN_W(LEN_W), .WIN_LG(WIN_LG), .TEST_LG(TEST_LG)
   ) u_clip (
      .req_len(req_len), .win_off(win_off), .test_mode(tgt == TGT_TEST),
      .len_out(clip_len)
   );

   assign bad     = !in_range || (tgt == TGT_RSVD);
   assign xl_err  = bad;
   assign xl_phys = bad ? '0 : route_pa;
   assign xl_len  = bad ? '0 : clip_len;

endmodule

// File: rtl/iwin_xlate_chk.sv
module iwin_xlate_chk #(
   parameter int     MAP_W = 16,
   parameter int     SEL_W = 1,
   parameter int     OFF_W = 24,
   parameter int     LEN_W = 16,
   parameter int     PA_W  = 32,
   parameter longint SPAN  = 64'h40000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             map_we,
   input logic [SEL_W-1:0] map_wsel,
   input logic [MAP_W-1:0] map_wdata,
   input logic [SEL_W-1:0] map_rsel,
   input logic [MAP_W-1:0] map_rdata,
   input logic [OFF_W-1:0] req_off,
   input logic [LEN_W-1:0] req_len,
   input logic [PA_W-1:0]  xl_phys,
   input logic [LEN_W-1:0] xl_len,
   input logic             xl_err
);

   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, req_off} >= (OFF_W + 1)'(SPAN)) |-> (xl_err && xl_len == '0 && xl_phys == '0)); // R3

   AST_ERR_NO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      xl_err |-> (xl_len == '0 && xl_phys == '0)); // R8

   AST_LEN_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      xl_len <= req_len); // R10

   AST_ZERO_LEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_len == '0) |-> (xl_len == '0)); // R11

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |=> (map_rsel != $past(map_wsel) || map_rdata == $past(map_wdata))); // R2

   AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !map_we |=> (map_rsel != $past(map_rsel) || $stable(map_rdata))); // R2

endmodule

bind iwin_xlate iwin_xlate_chk #(
   .MAP_W(MAP_W), .SEL_W(SEL_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .PA_W(PA_W), .SPAN(SPAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_wsel(map_wsel),
   .map_wdata(map_wdata), .map_rsel(map_rsel), .map_rdata(map_rdata),
   .req_off(req_off), .req_len(req_len), .xl_phys(xl_phys),
   .xl_len(xl_len), .xl_err(xl_err)
);

// File: tb/iwin_xlate_test.sv
`timescale 1ns/1ps
module iwin_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_we = 1'b0;
   logic [0:0]  map_wsel = '0;
   logic [15:0] map_wdata = '0;
   logic [0:0]  map_rsel = '0;
   logic [15:0] map_rdata;
   logic [23:0] req_off = '0;
   logic [15:0] req_len = '0;
   logic [31:0] xl_phys;
   logic [15:0] xl_len;
   logic        xl_err;

   logic [0:0]  alt_rsel = '0;
   logic [15:0] alt_rdata;
   logic [23:0] alt_off = '0;
   logic [15:0] alt_len = '0;
   logic [31:0] alt_phys;
   logic [15:0] alt_xlen;
   logic        alt_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] mdl [2];

   always #5 clk = ~clk;

   iwin_xlate uut (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_wsel(map_wsel),
      .map_wdata(map_wdata), .map_rsel(map_rsel), .map_rdata(map_rdata),
      .req_off(req_off), .req_len(req_len), .xl_phys(xl_phys),
      .xl_len(xl_len), .xl_err(xl_err)
   );

   iwin_xlate #(.BOOT_PROFILE(1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .map_we(1'b0), .map_wsel(1'b0),
      .map_wdata(16'h0), .map_rsel(alt_rsel), .map_rdata(alt_rdata),
      .req_off(alt_off), .req_len(alt_len), .xl_phys(alt_phys),
      .xl_len(alt_xlen), .xl_err(alt_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference for one request against a pair of map words
   function automatic void ref_xlate(input logic [15:0] m0, input logic [15:0] m1,
                                     input longint off, input longint len,
                                     output longint p, output longint l, output bit e);
      longint wo, idx, tgt, seg, room, t;
      logic [15:0] m;
      p = 0; l = 0; e = 0;
      if (off >= 64'h40000) begin
         e = 1;
         return;
      end
      idx = off / 64'h20000;
      wo  = off % 64'h20000;
      m   = (idx == 0) ? m0 : m1;
      tgt = (longint'(m) >> 12) & 3;
      seg = longint'(m) & 64'h7F;
      case (tgt)
         0: begin p = seg * 64'h20000 + wo; room = 64'h20000 - wo; end
         1: begin p = 64'h0100_0000 + 64'h20000 * idx + wo; room = 64'h20000 - wo; end
         3: begin t = wo % 64'h800; p = 64'h0100_0000 + t; room = 64'h800 - t; end
         default: begin e = 1; return; end
      endcase
      l = (len > room) ? room : len;
   endfunction

   task automatic cyc(input bit we, input int wsel, input int wdata, input int rsel,
                      input longint off, input longint len, input string tag);
      longint ep, el;
      bit ee;
      @(negedge clk);
      map_we    = we;
      map_wsel  = 1'(wsel);
      map_wdata = 16'(wdata);
      map_rsel  = 1'(rsel);
      req_off   = 24'(off);
      req_len   = 16'(len);
      #1;
      ref_xlate(mdl[0], mdl[1], off, len, ep, el, ee);
      check(xl_err == ee, tag, "err", longint'(xl_err), longint'(ee));
      check(xl_phys == 32'(ep), tag, "phys", longint'(xl_phys), ep);
      check(xl_len == 16'(el), tag, "len", longint'(xl_len), el);
      check(map_rdata == mdl[rsel], tag, "rdata", longint'(map_rdata), longint'(mdl[rsel]));
      @(posedge clk);
      if (we) mdl[wsel] = 16'(wdata);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      mdl[0] = 16'h0000;
      mdl[1] = 16'h007F;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values, both profiles
      cyc(0, 0, 0, 0, 24'h100, 4, "R1");
      cyc(0, 0, 0, 1, 24'h20004, 8, "R1");
      @(negedge clk);
      alt_rsel = 1'b0; alt_off = 24'h20010; alt_len = 16'd4;
      #1;
      check(alt_rdata == 16'h1000, "R1", "alt map0", longint'(alt_rdata), 64'h1000);
      check(alt_phys == 32'h0102_0010, "R1", "alt phys", longint'(alt_phys), 64'h0102_0010);
      check(alt_xlen == 16'd4 && !alt_err, "R1", "alt len", longint'(alt_xlen), 4);
      @(negedge clk);
      alt_rsel = 1'b1;
      #1;
      check(alt_rdata == 16'h1000, "R1", "alt map1", longint'(alt_rdata), 64'h1000);

      // R2 same-cycle write and translation of the same window
      cyc(1, 0, 16'h0005, 0, 24'h1FFFE, 8, "R2");
      // R6 and R10: unified segment 5, clipped at window end
      cyc(0, 0, 0, 0, 24'h1FFFE, 8, "R6");
      cyc(0, 0, 0, 0, 24'h00010, 16'hFFFF, "R10");
      // R7 and R4: window 1 to instruction memory
      cyc(1, 1, 16'h1000, 1, 24'h20040, 16, "R2");
      cyc(0, 0, 0, 1, 24'h20040, 16, "R7");
      cyc(0, 0, 0, 1, 24'h3FFFF, 16, "R4");
      // R8: reserved target
      cyc(1, 1, 16'h2000, 1, 24'h20000, 4, "R2");
      cyc(0, 0, 0, 1, 24'h20000, 4, "R8");
      // R9: test aliasing
      cyc(1, 0, 16'h3000, 0, 24'h7FC, 10, "R2");
      cyc(0, 0, 0, 0, 24'h7FC, 10, "R9");
      cyc(0, 0, 0, 0, 24'h10805, 16'h900, "R9");
      cyc(0, 0, 0, 0, 24'h1F800, 16'h800, "R9");
      // R5: bits outside target and segment fields ignored
      cyc(1, 0, 16'hCF85, 0, 24'h00020, 4, "R2");
      cyc(0, 0, 0, 0, 24'h00020, 4, "R5");
      cyc(1, 0, 16'h4F85, 0, 24'h00020, 4, "R5");
      cyc(0, 0, 0, 0, 24'h00020, 4, "R5");
      // R3: out of range
      cyc(0, 0, 0, 0, 24'h40000, 4, "R3");
      cyc(0, 0, 0, 1, 24'hFFFFFF, 4, "R3");
      cyc(0, 0, 0, 0, 24'h3FFFF, 1, "R3");
      // R11: zero length
      cyc(0, 0, 0, 0, 24'h00100, 0, "R11");

      // random mix of writes and requests
      for (int i = 0; i < 400; i++) begin
         bit we = ($urandom % 4) == 0;
         int wd = int'($urandom & 32'hFFFF);
         longint off = longint'($urandom % 32'h48000);
         longint len = ($urandom % 2) ? longint'($urandom % 64) : longint'($urandom & 32'hFFFF);
         cyc(we, int'($urandom % 2), wd, int'($urandom % 2), off, len, "R10");
      end

      finish_run();
   end

endmodule